// File: doc/BRIEF.md
# Bit-6 Address Swizzle Unit

This unit sits on a memory access path and rewrites one bit of each byte address so that accesses from the processor side land in the same memory channel that an interleaving graphics engine would pick. Bit 6 of the outgoing address becomes the XOR of incoming bit 6 with a chosen group of higher bits, taken from bits 9, 10, 11 and 17. The group is chosen by a mode. X-tiled and Y-tiled surfaces each have their own mode. Linear accesses are never altered.

Software or boot logic loads both modes through a small configuration port. When the memory layout does not allow a known pattern, the configuration code for "unknown" is written. The unit then falls back to no swizzling and raises a flag. This flag tells the page manager to keep the pages of tiled surfaces at fixed physical locations. Typical settings are 9_10 for X and 9 for Y. When the processor also mixes in bit 11, the settings are 9_10_11 and 9_11. When it mixes in bit 17, they are 9_10_17 and 9_17. Single-channel memory and uneven dual-channel memory use none.

Top module: `addr_swizzle`

## Requirements
- R1: After reset, both stored modes read 0 (none), `pin_pages` is 0 and `out_valid` is 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, and `out_addr` is the transformed address of the access presented in that earlier cycle.
- R3: Every bit of `out_addr` other than bit 6 equals the same bit of the input address.
- R4: An access with `in_tile` 0 (linear) or 3 (treated as linear) passes through unchanged, whatever modes are stored.
- R5: With `in_tile` 1 (X) the X mode applies, and with `in_tile` 2 (Y) the Y mode applies. The mode codes and the bits each one XORs into bit 6 are: 0 none, 1 {9}, 2 {9,10}, 3 {9,11}, 4 {9,10,11}, 5 {9,17}, 6 {9,10,17}.
- R6: With `cfg_we` high at a clock edge, the two mode fields are stored at that edge. They govern accesses presented after that edge. An access presented in the same cycle as the write still uses the old modes.
- R7: A write where either field holds code 7 (unknown) stores none in both modes and sets `pin_pages` to 1. A later write with two valid codes stores them and clears `pin_pages`.
- R8: While `cfg_we` is low, the stored modes and `pin_pages` keep their values, whatever is on the mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_x_mode | input | 3 | Mode code to store for X-tiled accesses |
| cfg_y_mode | input | 3 | Mode code to store for Y-tiled accesses |
| mode_x_q | output | 3 | Stored X mode |
| mode_y_q | output | 3 | Stored Y mode |
| pin_pages | output | 1 | Set when the last write carried an unknown code |
| in_valid | input | 1 | Access valid |
| in_addr | input | AW | Byte address of the access |
| in_tile | input | 2 | Surface layout: 0 linear, 1 X, 2 Y, 3 linear |
| out_valid | output | 1 | Registered access valid |
| out_addr | output | AW | Registered, swizzled address |

## Verification
The bench uses the default address width of 32. Every mode pair from 0 to 6 is loaded, and under each pair all four tile codes are driven against all 32 combinations of bits 6, 9, 10, 11 and 17, with random values in the other bits. This sweep covers the whole XOR table in both tiling kinds and the linear pass-through. It also shows that the untouched bits survive. Directed sequences cover a write in the same cycle as an access, unknown codes in either field, and holding the configuration with the strobe low.

// File: rtl/addr_swizzle.sv
module addr_swizzle #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_x_mode,
  input  logic [2:0]    cfg_y_mode,
  output logic [2:0]    mode_x_q,
  output logic [2:0]    mode_y_q,
  output logic          pin_pages,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_tile,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);

  localparam logic [2:0] MODE_NONE = 3'd0;
  localparam logic [2:0] MODE_UNK  = 3'd7;
  localparam logic [1:0] TILE_X    = 2'd1;
  localparam logic [1:0] TILE_Y    = 2'd2;

  // returns enables for {bit17, bit11, bit10, bit9}
  function automatic logic [3:0] src_bits(input logic [2:0] m);
    case (m)
      3'd1:    src_bits = 4'b0001;
      3'd2:    src_bits = 4'b0011;
      3'd3:    src_bits = 4'b0101;
      3'd4:    src_bits = 4'b0111;
      3'd5:    src_bits = 4'b1001;
      3'd6:    src_bits = 4'b1011;
      default: src_bits = 4'b0000;
    endcase
  endfunction

  logic       cfg_bad;
  logic [3:0] pick;
  logic       flip;
  logic [AW-1:0] swz_addr;

  assign cfg_bad = (cfg_x_mode == MODE_UNK) || (cfg_y_mode == MODE_UNK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_x_q  <= MODE_NONE;
      mode_y_q  <= MODE_NONE;
      pin_pages <= 1'b0;
    end else if (cfg_we) begin
      mode_x_q  <= cfg_bad ? MODE_NONE : cfg_x_mode;
      mode_y_q  <= cfg_bad ? MODE_NONE : cfg_y_mode;
      pin_pages <= cfg_bad;
    end
  end

  assign pick = (in_tile == TILE_X) ? src_bits(mode_x_q) :
                (in_tile == TILE_Y) ? src_bits(mode_y_q) : 4'b0000;
  assign flip = ^(pick & {in_addr[17], in_addr[11], in_addr[10], in_addr[9]});
  assign swz_addr = {in_addr[AW-1:7], in_addr[6] ^ flip, in_addr[5:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_addr  <= swz_addr;
    end
  end

endmodule

// File: rtl/addr_swizzle_chk.sv
module addr_swizzle_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_x_mode,
  input logic [2:0]    cfg_y_mode,
  input logic [2:0]    mode_x_q,
  input logic [2:0]    mode_y_q,
  input logic          pin_pages,
  input logic          in_valid,
  input logic [AW-1:0] in_addr,
  input logic [1:0]    in_tile,
  input logic          out_valid,
  input logic [AW-1:0] out_addr
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_addr[AW-1:7] == $past(in_addr[AW-1:7]) && out_addr[5:0] == $past(in_addr[5:0]));
  a_r4_linear_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_tile == 2'd0 || in_tile == 2'd3)) |=> out_addr == $past(in_addr));
  a_r5_none_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tile == 2'd1 && mode_x_q == 3'd0) |=> out_addr == $past(in_addr));
  a_r7_unknown_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_x_mode == 3'd7 || cfg_y_mode == 3'd7)) |=> pin_pages && mode_x_q == 3'd0 && mode_y_q == 3'd0);
  a_r7_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_x_mode != 3'd7 && cfg_y_mode != 3'd7) |=> !pin_pages && mode_x_q == $past(cfg_x_mode) && mode_y_q == $past(cfg_y_mode));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_x_q) && $stable(mode_y_q) && $stable(pin_pages));

endmodule

bind addr_swizzle addr_swizzle_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_x_mode(cfg_x_mode),
  .cfg_y_mode(cfg_y_mode), .mode_x_q(mode_x_q), .mode_y_q(mode_y_q),
  .pin_pages(pin_pages), .in_valid(in_valid), .in_addr(in_addr),
  .in_tile(in_tile), .out_valid(out_valid), .out_addr(out_addr)
);

// File: tb/tb_addr_swizzle.sv
`timescale 1ns/1ps
module tb_addr_swizzle;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_x_mode = '0;
  logic [2:0]    cfg_y_mode = '0;
  logic [2:0]    mode_x_q, mode_y_q;
  logic          pin_pages;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [1:0]    in_tile = '0;
  logic          out_valid;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_swizzle #(.AW(AW)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bit 6 result from the requirement table, arithmetic form
  function automatic logic [AW-1:0] model(input logic [AW-1:0] a, input logic [1:0] t,
                                          input int mx, input int my);
    int m;
    logic f;
    m = (t == 2'd1) ? mx : (t == 2'd2) ? my : 0;
    f = 1'b0;
    if (m >= 1 && m <= 6) f ^= a[9];
    if (m == 2 || m == 4 || m == 6) f ^= a[10];
    if (m == 3 || m == 4) f ^= a[11];
    if (m >= 5 && m <= 6) f ^= a[17];
    model = a;
    model[6] = a[6] ^ f;
  endfunction

  task automatic write_cfg(input logic [2:0] x, input logic [2:0] y);
    @(negedge clk);
    cfg_we = 1'b1; cfg_x_mode = x; cfg_y_mode = y;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [1:0] t, input int mx,
                        input int my, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_tile = t;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk(req, 64'(out_addr), 64'(model(a, t, mx, my)));
  endtask

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode_x", 64'(mode_x_q), 0);
    chk("R1 mode_y", 64'(mode_y_q), 0);
    chk("R1 pin", 64'(pin_pages), 0);
    chk("R1 out_valid", 64'(out_valid), 0);

    // R5 R4 R3 R2 sweep
    for (int mx = 0; mx < 7; mx++) begin
      for (int my = 0; my < 7; my++) begin
        write_cfg(3'(mx), 3'(my));
        chk("R6 stored x", 64'(mode_x_q), 64'(mx));
        chk("R6 stored y", 64'(mode_y_q), 64'(my));
        for (int t = 0; t < 4; t++) begin
          for (int p = 0; p < 32; p++) begin
            a = AW'($urandom);
            a[6] = p[0]; a[9] = p[1]; a[10] = p[2]; a[11] = p[3]; a[17] = p[4];
            access(a, 2'(t), mx, my, (t == 0 || t == 3) ? "R4 linear" : "R5 R3 swizzle");
          end
        end
      end
    end

    // R2 idle cycle after an access
    @(negedge clk);
    chk("R2 idle", 64'(out_valid), 0);

    // R6 same-cycle write uses old mode
    write_cfg(3'd2, 3'd1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_x_mode = 3'd0; cfg_y_mode = 3'd0;
    in_valid = 1'b1; in_tile = 2'd1; in_addr = 32'h0000_0200;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R6 old mode", 64'(out_addr), 64'h0000_0240);
    access(32'h0000_0200, 2'd1, 0, 0, "R6 new mode");

    // R7 unknown code
    write_cfg(3'd7, 3'd1);
    chk("R7 pin set", 64'(pin_pages), 1);
    chk("R7 x none", 64'(mode_x_q), 0);
    chk("R7 y none", 64'(mode_y_q), 0);
    access(32'h0002_0200, 2'd2, 0, 0, "R7 no swizzle");
    write_cfg(3'd4, 3'd7);
    chk("R7 pin y", 64'(pin_pages), 1);
    chk("R7 x none y", 64'(mode_x_q), 0);
    write_cfg(3'd6, 3'd5);
    chk("R7 pin clear", 64'(pin_pages), 0);
    chk("R7 x kept", 64'(mode_x_q), 6);

    // R8 hold with strobe low
    @(negedge clk);
    cfg_x_mode = 3'd7; cfg_y_mode = 3'd3;
    repeat (3) @(negedge clk);
    chk("R8 x hold", 64'(mode_x_q), 6);
    chk("R8 y hold", 64'(mode_y_q), 5);
    chk("R8 pin hold", 64'(pin_pages), 0);
    access(32'h0002_0000, 2'd2, 6, 5, "R8 mode in use");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule